// File: doc/BRIEF.md
# 1K x 4 Static Memory with Asynchronous-Style Timing

This block models a small static memory of 1024 four-bit words. It has a separate input bus and output bus, an active-low select and an active-low write strobe. A fast system clock samples the control pins on every rising edge. A write is committed on the edge at which the sampled write strobe goes from low to high. The word and the address used are the ones present on that edge.

The read path behaves like a plain asynchronous memory. While the block is deselected or a write pulse is in progress, the output is forced to zero. When a new address arrives during reading, the previous word stays on the output for a short interval. The output then drops to a zero filler, and the new word appears once the access delay has elapsed. A `q_valid` flag is high only while the output carries real memory data.

All delays are parameters counted in system-clock cycles. After reset the output path and the delay state are cleared. The storage contents are left undefined.

Top module: `async_sram_1kx4`

## Requirements
- R1: The block stores 2**ADDR_W words of DATA_W bits (1024 x 4 by default). Each word is read back unchanged from the address it was written to.
- R2: When `cs_n` is sampled high on an edge, `q` is 0 and `q_valid` is 0 after that edge, whatever `we_n` is.
- R3: When `cs_n` and `we_n` are both sampled low on an edge, `q` is 0 and `q_valid` is 0 after that edge.
- R4: A write is committed on the edge where `we_n` is sampled high after being sampled low on the previous edge, with `cs_n` low. It stores the `d` and `addr` values sampled on that edge, not earlier values from the pulse.
- R5: If `cs_n` is sampled high on the edge where `we_n` rises, nothing is stored.
- R6: During reading (`cs_n` low, `we_n` high), an address change sampled on edge E causes `q` to show the new word, with `q_valid` = 1, from edge E+ACC_CYC on.
- R7: On a read-to-read address change at edge E, the previous `q` and `q_valid` are kept after edges E to E+HOLD_CYC-1. From then until E+ACC_CYC-1, `q` is 0 and `q_valid` is 0. `q_valid` = 0 always implies `q` = 0.
- R8: After a write commits on edge E with the block still selected, `q` is 0 and `q_valid` is 0 until E+REC_CYC-1. From E+REC_CYC on, `q` shows the written word with `q_valid` = 1.
- R9: Entering a read from the deselected state gives a zero filler from the first edge, with no hold of older data. The word appears at E+ACC_CYC.
- R10: While `rst_n` is low, `q` is 0 and `q_valid` is 0.
- R11: While reading with a steady address, `q` does not change once `q_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Active-low asynchronous reset of the output path and counters |
| addr | input | ADDR_W | Word address |
| d | input | DATA_W | Write data |
| cs_n | input | 1 | Active-low select |
| we_n | input | 1 | Active-low write strobe; the rising edge commits |
| q | output | DATA_W | Read data, 0 when not valid |
| q_valid | output | 1 | High while `q` carries memory data |

## Verification
The bound checker watches the forcing rules on every cycle. A high select, or a write pulse, must produce a zero, invalid output on the next edge. An invalid output must read as zero. The valid flag may rise only right after a sampled read. A valid output that stays valid must not change. Only the bench scenarios can show whether the right word came back, and on exactly which edge. The write-at-trailing-edge semantics, the refused write when deselected at the strobe rise, and the exact hold, access and recovery cycle counts are all checked there. The bench does this by writing every address, re-reading every address with a per-cycle timing check, and running targeted pulse and selection sequences.

// File: rtl/async_sram_1kx4.sv
module async_sram_1kx4 #(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 4,
  parameter int ACC_CYC  = 4,
  parameter int HOLD_CYC = 1,
  parameter int REC_CYC  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] d,
  input  logic              cs_n,
  input  logic              we_n,
  output logic [DATA_W-1:0] q,
  output logic              q_valid
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int MAXD  = (ACC_CYC > REC_CYC) ? ACC_CYC : REC_CYC;
  localparam int CNT_W = $clog2(MAXD + 1);
  localparam logic [CNT_W-1:0] ACC_C  = CNT_W'(ACC_CYC);
  localparam logic [CNT_W-1:0] REC_C  = CNT_W'(REC_CYC);
  localparam logic [CNT_W-1:0] HOLD_C = CNT_W'(HOLD_CYC);
  localparam logic HOLD_ON = (HOLD_CYC > 0);

  logic [DATA_W-1:0] mem [DEPTH];
  logic              we_prev, rd_prev, hold_ok;
  logic [ADDR_W-1:0] addr_prev;
  logic [CNT_W-1:0]  cnt, target;

  wire rd     = !cs_n && we_n;
  wire commit = rd && !we_prev;
  wire start  = rd && (!rd_prev || addr != addr_prev);

  always_ff @(posedge clk)
    if (commit) mem[addr] <= d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_prev   <= 1'b1;
      rd_prev   <= 1'b0;
      addr_prev <= '0;
      hold_ok   <= 1'b0;
      cnt       <= '0;
      target    <= '0;
      q         <= '0;
      q_valid   <= 1'b0;
    end else begin
      we_prev   <= we_n;
      rd_prev   <= rd;
      addr_prev <= addr;
      if (!rd) begin
        cnt     <= '0;
        q       <= '0;
        q_valid <= 1'b0;
      end else if (start) begin
        cnt     <= CNT_W'(1);
        target  <= commit ? REC_C : ACC_C;
        hold_ok <= rd_prev && HOLD_ON;
        if (!(rd_prev && HOLD_ON)) begin
          q       <= '0;
          q_valid <= 1'b0;
        end
      end else if (cnt >= target) begin
        q       <= mem[addr];
        q_valid <= 1'b1;
      end else begin
        cnt <= cnt + CNT_W'(1);
        if (!(hold_ok && cnt < HOLD_C)) begin
          q       <= '0;
          q_valid <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/async_sram_1kx4_chk.sv
module async_sram_1kx4_chk #(
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              we_n,
  input logic [DATA_W-1:0] q,
  input logic              q_valid
);
  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (q == '0 && !q_valid)); // R2
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !we_n) |=> (q == '0 && !q_valid)); // R3
  AST_FILLER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !q_valid |-> q == '0); // R7
  AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_valid) |-> $past(!cs_n && we_n)); // R6
  AST_VALID_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && $past(q_valid)) |-> $stable(q)); // R11
endmodule

bind async_sram_1kx4 async_sram_1kx4_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .q(q), .q_valid(q_valid)
);

// File: tb/test_async_sram_1kx4.sv
module test_async_sram_1kx4;
  localparam int AW = 10, DW = 4, ACC = 4, HOLD = 1, REC = 3;
  localparam int N = 1 << AW;

  logic clk = 0, rst_n = 0, cs_n = 1, we_n = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] d = '0;
  logic [DW-1:0] q;
  logic q_valid;
  int nchk = 0, nerr = 0;

  always #2 clk = ~clk;

  async_sram_1kx4 #(.ADDR_W(AW), .DATA_W(DW), .ACC_CYC(ACC), .HOLD_CYC(HOLD), .REC_CYC(REC))
    i_async_sram_1kx4 (.clk(clk), .rst_n(rst_n), .addr(addr), .d(d), .cs_n(cs_n),
                       .we_n(we_n), .q(q), .q_valid(q_valid));

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 7 + 3) & 15);
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input logic [DW-1:0] eq, input logic ev, input string tag);
    nchk++;
    if (q !== eq || q_valid !== ev) begin
      nerr++;
      $display("FAIL %s: q=%h valid=%b expected q=%h valid=%b", tag, q, q_valid, eq, ev);
    end
  endtask

  // address change during reading, or selection, with per-edge timing check
  task automatic access(input int a, input logic [DW-1:0] exp, input logic hold,
                        input logic [DW-1:0] old, input string tag);
    addr = AW'(a);
    for (int j = 0; j <= ACC; j++) begin
      step();
      if (j == ACC) chk(exp, 1'b1, tag);
      else if (hold && j < HOLD) chk(old, 1'b1, "R7 hold");
      else chk('0, 1'b0, hold ? "R7 filler" : "R9 filler");
    end
  endtask

  // after the commit edge has been observed (j = 0)
  task automatic recover(input logic [DW-1:0] exp);
    chk('0, 1'b0, "R8 at commit");
    for (int j = 1; j <= REC; j++) begin
      step();
      if (j == REC) chk(exp, 1'b1, "R8 recovered");
      else chk('0, 1'b0, "R8 waiting");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) step();
    chk('0, 1'b0, "R10 reset");
    rst_n = 1;
    step();
    chk('0, 1'b0, "R2 idle");

    // R1 R3 fill every address
    for (int a = 0; a < N; a++) begin
      cs_n = 0; we_n = 0; addr = AW'(a); d = pat(a);
      step();
      chk('0, 1'b0, "R3 write pulse");
      we_n = 1;
      step();
      if (a == N - 1) recover(pat(a));
      else chk('0, 1'b0, "R8 at commit");
    end

    // R1 R6 R7 read every address back
    for (int a = 0; a < N; a++)
      access(a, pat(a), 1'b1, pat(a == 0 ? N - 1 : a - 1), "R1 R6 readback");

    // R2 R5 strobe rises while deselected
    cs_n = 1; we_n = 1; step(); chk('0, 1'b0, "R2 deselect");
    we_n = 0; addr = 5; d = ~pat(5); step(); chk('0, 1'b0, "R2 deselect we low");
    we_n = 1; step(); chk('0, 1'b0, "R2 deselect we rise");
    cs_n = 0;
    access(5, pat(5), 1'b0, '0, "R5 R9 no write");

    // R4 data and address taken at the trailing edge
    we_n = 0; addr = 8; d = 4'h1; step(); chk('0, 1'b0, "R3 pulse");
    d = 4'h6; step(); chk('0, 1'b0, "R3 pulse");
    we_n = 1; addr = 9; d = 4'hB; step();
    recover(4'hB);
    access(8, pat(8), 1'b1, 4'hB, "R4 addr8 untouched");
    access(9, 4'hB, 1'b1, pat(8), "R4 addr9 written");

    // R11 steady read keeps the word
    repeat (5) begin step(); chk(4'hB, 1'b1, "R11 steady"); end

    // R9 select from write-free idle
    cs_n = 1; step(); chk('0, 1'b0, "R2 deselect");
    cs_n = 0;
    access(100, pat(100), 1'b0, '0, "R9 select");

    // R10 reset clears output mid-read
    rst_n = 0; #1; chk('0, 1'b0, "R10 async reset");
    step(); rst_n = 1; cs_n = 1; step();

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nerr);
    $finish;
  end
endmodule